// File: doc/BRIEF.md
# Sparse prefix-tree carry-select adder

This block adds two unsigned or two's complement operands and a carry-in, and returns the sum and the carry-out. The carry network is a parallel-prefix tree that works on groups of bits rather than on single bits. Each group of `SPARSE` bits first reduces to one (generate, propagate) pair. The tree then resolves the carry entering every group. That carry picks between two local sums made in advance inside the group, one for carry-in 0 and one for carry-in 1.

The tree combine node takes either two or four pairs (`RADIX` 2 or 4). The group width `SPARSE` is 1, 2 or 4, so the tree resolves every carry, every second carry or every fourth carry. The carry-in enters as the generate term of an extra node below bit 0. It therefore takes part in every prefix, and the carry-out is simply the prefix of the top node. An optional output register (`REGISTERED`=1) adds one cycle of latency for timing closure. With `REGISTERED`=0 the block is purely combinational from operands to results.

Top module: `sparse_adder`

## Requirements
- R1: `sum` equals (a + b + cin) modulo 2^WIDTH for every legal RADIX (2, 4) and SPARSE (1, 2, 4) setting.
- R2: `cout` equals bit WIDTH of the full-width sum a + b + cin.
- R3: A carry that enters at the lowest position propagates through the whole width. All-ones plus 0 with cin=1, all-ones plus 1 with cin=0, and 0x5555... plus 0xAAAA... with cin=1 each give sum 0 and cout 1.
- R4: Radix-2 and radix-4 trees with the same SPARSE produce identical sum and cout for every input.
- R5: The carry entering each group equals the carry-out of the preceding group's selected local sum, so every SPARSE setting gives the same result as SPARSE=1.
- R6: With REGISTERED=0, outputs follow inputs in the same cycle. With REGISTERED=1, the outputs show the result of the inputs present at the previous rising clock edge, and they read zero while rst_n is low.
- R7: Zero plus zero with cin=0 gives sum 0 and cout 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| cout | output | 1 | Carry-out |

## Verification
In the combinational configurations, sum and carry-out are due in the same cycle as the operands. The bench drives each operand set on a falling edge and reads all six radix/sparseness variants a quarter period later, well away from any rising edge. In the registered variant the result is due after exactly one rising edge. The bench reads it on the next falling edge and only then drives the following operand set, so each registered value is matched to the stimulus that produced it.

// File: rtl/sparse_adder.sv
module sparse_adder #(
  parameter int WIDTH      = 64,
  parameter int RADIX      = 2,
  parameter int SPARSE     = 1,
  parameter int REGISTERED = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NG     = WIDTH / SPARSE;
  localparam int NN     = NG + 1;
  localparam int LOG2N  = $clog2(NN);
  localparam int LEVELS = (RADIX == 4) ? (LOG2N + 1) / 2 : LOG2N;

  logic [NG-1:0]    gg, gp, co0, co1;
  logic [WIDTH-1:0] s0, s1, sum_c;
  logic [NG:0]      tc;
  logic             cout_c;

  genvar k, lv, n, t;

  // Per-group reduction and conditional sums
  for (k = 0; k < NG; k++) begin : grp
    logic [SPARSE-1:0] ga, gb;
    assign ga = a[k*SPARSE +: SPARSE];
    assign gb = b[k*SPARSE +: SPARSE];
    assign {co0[k], s0[k*SPARSE +: SPARSE]} = {1'b0, ga} + {1'b0, gb};
    assign {co1[k], s1[k*SPARSE +: SPARSE]} = {1'b0, ga} + {1'b0, gb} + (SPARSE+1)'(1);
    assign gg[k] = co0[k];
    assign gp[k] = &(ga | gb);
    assign sum_c[k*SPARSE +: SPARSE] = tc[k] ? s1[k*SPARSE +: SPARSE] : s0[k*SPARSE +: SPARSE];

    a_group_chain : assert property (@(posedge clk) disable iff (!rst_n)
      tc[k+1] == (tc[k] ? co1[k] : co0[k]))
      else $error("p_group_chain_r5 group %0d", k);
  end

  // Sparse prefix tree; node 0 carries cin
  for (lv = 0; lv <= LEVELS; lv++) begin : lvl
    logic [NN-1:0] g, p;
    if (lv == 0) begin : base
      assign g = {gg, cin};
      assign p = {gp, 1'b0};
    end else begin : stage
      localparam int D = RADIX ** (lv - 1);
      for (n = 0; n < NN; n++) begin : node
        for (t = 0; t < RADIX; t++) begin : tap
          logic tg, tp;
          if (t == 0) begin : own
            assign tg = lvl[lv-1].g[n];
            assign tp = lvl[lv-1].p[n];
          end else if (n - t*D >= 0) begin : link
            assign tg = tap[t-1].tg | (tap[t-1].tp & lvl[lv-1].g[n - t*D]);
            assign tp = tap[t-1].tp & lvl[lv-1].p[n - t*D];
          end else begin : pass
            assign tg = tap[t-1].tg;
            assign tp = tap[t-1].tp;
          end
        end
        assign g[n] = tap[RADIX-1].tg;
        assign p[n] = tap[RADIX-1].tp;
      end
    end
  end

  assign tc     = lvl[LEVELS].g;
  assign cout_c = tc[NG];

  if (REGISTERED != 0) begin : out_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum  <= '0;
        cout <= 1'b0;
      end else begin
        sum  <= sum_c;
        cout <= cout_c;
      end
    end
  end else begin : out_comb
    assign sum  = sum_c;
    assign cout = cout_c;
  end

  p_lsb_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    sum_c[0] == (a[0] ^ b[0] ^ cin));

  p_cout_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    cout_c == ((a[WIDTH-1] & b[WIDTH-1]) | ((a[WIDTH-1] ^ b[WIDTH-1]) & ~sum_c[WIDTH-1])));

  p_full_carry_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (&a && b == '0 && cin) |-> (sum_c == '0 && cout_c));

  p_zero_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (a == '0 && b == '0 && !cin) |-> (sum_c == '0 && !cout_c));

endmodule

// File: tb/sparse_adder_bench.sv
module sparse_adder_bench;
  localparam int PERIOD = 10;
  localparam int W      = 64;
  localparam int NCFG   = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] s_o [NCFG];
  logic         c_o [NCFG];
  logic [W-1:0] s_reg;
  logic         c_reg;
  int           n_cmp = 0;
  int           n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  for (genvar gc = 0; gc < NCFG; gc++) begin : cfg
    sparse_adder #(.WIDTH(W), .RADIX(gc < 3 ? 2 : 4), .SPARSE(1 << (gc % 3)), .REGISTERED(0))
      u_sparse_adder (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
                      .sum(s_o[gc]), .cout(c_o[gc]));
  end

  sparse_adder #(.WIDTH(W), .RADIX(4), .SPARSE(4), .REGISTERED(1))
    u_sparse_adder (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
                    .sum(s_reg), .cout(c_reg));

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string tag);
    logic [W:0] exp;
    @(negedge clk);
    a = x; b = y; cin = c;
    exp = ref_add(x, y, c);
    #(PERIOD/4);
    for (int i = 0; i < NCFG; i++) begin
      chk($sformatf("R1 sum cfg%0d %s", i, tag), {1'b0, s_o[i]}, {1'b0, exp[W-1:0]});
      chk($sformatf("R2 cout cfg%0d %s", i, tag), {{W{1'b0}}, c_o[i]}, {{W{1'b0}}, exp[W]});
    end
    for (int i = 0; i < 3; i++)
      chk($sformatf("R4 radix2 vs radix4 sparse%0d %s", 1 << i, tag),
          {c_o[i+3], s_o[i+3]}, {c_o[i], s_o[i]});
    for (int i = 1; i < 3; i++)
      chk($sformatf("R5 sparse%0d vs sparse1 %s", 1 << i, tag), {c_o[i], s_o[i]}, {c_o[0], s_o[0]});
    if (tag != "")
      for (int i = 0; i < NCFG; i++)
        chk($sformatf("%s cfg%0d", tag, i), {c_o[i], s_o[i]}, exp);
    @(negedge clk);
    chk($sformatf("R6 registered result %s", tag), {c_reg, s_reg}, exp);
  endtask

  initial begin
    #(PERIOD * 60000);
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    a = '1; b = 64'h1234; cin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 reset clears register", {c_reg, s_reg}, '0);
    rst_n = 1'b1;

    run_vec('0, '0, 1'b0, "R7 zero");
    run_vec('1, 64'd1, 1'b0, "R3 ones plus one");
    run_vec('1, '0, 1'b1, "R3 ones plus cin");
    run_vec({32{2'b01}}, {32{2'b10}}, 1'b1, "R3 alternating");
    run_vec({32{2'b10}}, {32{2'b10}}, 1'b0, "");
    run_vec({32{2'b01}}, {32{2'b01}}, 1'b1, "");
    run_vec('1, '1, 1'b1, "");
    run_vec(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "");
    run_vec(64'h0F0F_0F0F_0F0F_0F0F, 64'hF0F0_F0F0_F0F0_F0F1, 1'b0, "");

    for (int v = 0; v < 400; v++) begin
      logic [W-1:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (v % 8 == 0) y = ~x;
      run_vec(x, y, 1'($urandom), "");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule